// File: doc/BRIEF.md
# Prefix-Aware Operand Address Generator

This block sits between the byte fetch path and the execute stage of an 8-bit core that has a 16-bit address space. It takes the bytes of one instruction in order: an optional prefix byte, then the opcode, then any address bytes. From these it works out where the operand lives. The result is one of five things: a 16-bit effective address, an immediate byte, the accumulator, an index register, or no operand at all. The block also reports which index register, the first or the second, the instruction ended up using.

Two prefix bytes change how the opcode's mode field is read. One prefix swaps the first index register for the second. This applies everywhere the first index register appears, including where the opcode names it as the operand itself. The other prefix adds one pointer dereference. In that case the address byte is a pointer into page zero, and the block reads the real address from memory through a one-cycle-latency read port. The real address is one byte, or two bytes with the high byte first, and it is indexed afterwards when the mode is indexed.

Top module: `opnd_addr_gen`

## Requirements
- R1: After reset, `done_o` is 0, `byte_rdy` is 1 and `mem_rd_en` is 0.
- R2: Only the first byte of an instruction can be a prefix. 0x90 selects the register swap, 0x92 selects one pointer indirection, and 0x91 selects both. When a prefix-valued byte follows a prefix, it is decoded as an opcode, and no prefix carries over to the next instruction.
- R3: When opcode bit 7 is 1, bits 6:4 choose the mode. The codes are: 010 immediate byte (kind 2, value in `ea_o[7:0]`), 011 one-byte address, 100 two-byte address (high byte first), 101 index plus two-byte offset, 110 index plus one-byte offset, and 111 index alone. All address modes report kind 1.
- R4: When opcode bit 7 is 0, bits 6:4 choose the mode. The codes are: 011 one-byte address, 100 accumulator (kind 3, `ea_o` 0), 101 index register as operand (kind 4, `ea_o` 0), 110 index plus one-byte offset, and 111 index alone.
- R5: An index is added to its base at full 16-bit width. So 0xFF plus an index of 0xFF gives 0x01FE.
- R6: Under the swap prefix, indexed modes and the register-operand mode use `idx_y`, and `use_y_o` is 1. Otherwise they use `idx_x`. `use_y_o` is 0 for every kind other than address and register.
- R7: With indirection on a one-byte-address or one-byte-offset mode, the block reads once at address {0x00, pointer}. It takes the returned byte as the base address and indexes it when the mode is indexed.
- R8: With indirection on a two-byte-address or two-byte-offset mode, only one pointer byte follows the opcode. The block reads at the pointer and then at the pointer plus one, computed at full width so that 0xFF is followed by 0x0100. The first byte read is the high byte.
- R9: The indirection prefix has no effect on the immediate, accumulator, register-operand and index-alone modes. In these modes the block makes no memory read, and the result is the same as without the prefix.
- R10: Opcode 0xA7 is flagged as illegal, with or without a prefix. `done_o` pulses with `illegal_o` = 1 and kind 0, and the block consumes no operand byte.
- R11: Any other mode value, for either opcode class, gives kind 0 and consumes no operand byte.
- R12: `done_o` is a one-cycle pulse. It comes 1 cycle after the last byte is accepted when no read is needed, 3 cycles after when one read is needed, and 4 cycles after when two reads are needed. `byte_rdy` stays 0 while reads are in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Instruction byte present |
| byte_in | input | 8 | Instruction byte |
| byte_rdy | output | 1 | Block takes a byte this cycle when `byte_vld` is 1 |
| idx_x | input | 8 | First index register value |
| idx_y | input | 8 | Second index register value |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| done_o | output | 1 | Result valid pulse |
| ea_o | output | 16 | Effective address, or immediate byte in the low half |
| kind_o | output | 3 | 0 none, 1 address, 2 immediate, 3 accumulator, 4 register |
| use_y_o | output | 1 | Second index register was used |
| illegal_o | output | 1 | Reserved opcode seen |

## Verification
The result is due at one of three distances from the edge that accepts the last instruction byte: one edge for direct modes, three edges for a single pointer read, and four edges for a pair of reads. Each vector records its expected distance. After the last byte goes in, the bench samples `done_o` on falling edges and compares the count with that distance. It also counts the read requests made during the instruction. A separate directed test steps through a two-byte dereference on falling edges and checks the request address, the ready signal and the result on the exact cycle each one is due.

// File: rtl/oag_pkg.sv
package oag_pkg;

    localparam logic [7:0] OPC_RESERVED = 8'hA7;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_MEM  = 3'd1,
        K_IMM  = 3'd2,
        K_ACC  = 3'd3,
        K_REG  = 3'd4
    } okind_e;

    // bit 0: register swap, bit 1: pointer indirection
    typedef enum logic [1:0] {
        PF_NONE = 2'd0,
        PF_SWAP = 2'd1,
        PF_IND  = 2'd2,
        PF_BOTH = 2'd3
    } pfx_e;

    typedef struct packed {
        okind_e     kind;
        logic       use_y;
        logic       indirect;
        logic [1:0] nbytes;
        logic       wide;
        logic       indexed;
        logic       illegal;
    } mode_t;

    typedef enum logic [2:0] {
        ST_OPC = 3'd0,
        ST_B1  = 3'd1,
        ST_B2  = 3'd2,
        ST_RA  = 3'd3,
        ST_RB  = 3'd4,
        ST_RC  = 3'd5
    } st_e;

    function automatic pfx_e pfx_of(input logic [7:0] b);
        case (b)
            8'h90:   return PF_SWAP;
            8'h91:   return PF_BOTH;
            8'h92:   return PF_IND;
            default: return PF_NONE;
        endcase
    endfunction

endpackage

// File: rtl/oag_mode_dec.sv
module oag_mode_dec
    import oag_pkg::*;
(
    input  logic [7:0] opc,
    input  pfx_e       pfx,
    output mode_t      m
);
    logic swap;
    logic ind;

    assign swap = pfx[0];
    assign ind  = pfx[1];

    always_comb begin
        m = '0;
        m.kind = K_NONE;
        if (opc == OPC_RESERVED) begin
            m.illegal = 1'b1;
        end else if (opc[7]) begin
            case (opc[6:4])
                3'b010: begin m.kind = K_IMM; m.nbytes = 2'd1; end
                3'b011: begin m.kind = K_MEM; m.nbytes = 2'd1; m.indirect = ind; end
                3'b100: begin
                    m.kind = K_MEM; m.wide = 1'b1; m.indirect = ind;
                    m.nbytes = ind ? 2'd1 : 2'd2;
                end
                3'b101: begin
                    m.kind = K_MEM; m.wide = 1'b1; m.indirect = ind; m.indexed = 1'b1;
                    m.nbytes = ind ? 2'd1 : 2'd2;
                end
                3'b110: begin
                    m.kind = K_MEM; m.nbytes = 2'd1; m.indirect = ind; m.indexed = 1'b1;
                end
                3'b111: begin m.kind = K_MEM; m.indexed = 1'b1; end
                default: m.kind = K_NONE;
            endcase
        end else begin
            case (opc[6:4])
                3'b011: begin m.kind = K_MEM; m.nbytes = 2'd1; m.indirect = ind; end
                3'b100: m.kind = K_ACC;
                3'b101: m.kind = K_REG;
                3'b110: begin
                    m.kind = K_MEM; m.nbytes = 2'd1; m.indirect = ind; m.indexed = 1'b1;
                end
                3'b111: begin m.kind = K_MEM; m.indexed = 1'b1; end
                default: m.kind = K_NONE;
            endcase
        end
        m.use_y = swap & (m.indexed | (m.kind == K_REG));
    end
endmodule

// File: rtl/oag_idx_add.sv
module oag_idx_add #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] idx,
    input  logic          en,
    output logic [AW-1:0] sum
);
    // full-width sum: no wrap inside the low byte
    assign sum = base + (en ? AW'(idx) : AW'(0));
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
    import oag_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byte_vld,
    input  logic [DW-1:0]   byte_in,
    output logic            byte_rdy,
    input  logic [DW-1:0]   idx_x,
    input  logic [DW-1:0]   idx_y,
    output logic            mem_rd_en,
    output logic [2*DW-1:0] mem_rd_addr,
    input  logic [DW-1:0]   mem_rd_data,
    output logic            done_o,
    output logic [2*DW-1:0] ea_o,
    output logic [2:0]      kind_o,
    output logic            use_y_o,
    output logic            illegal_o
);
    localparam int AW = 2 * DW;

    typedef struct packed {
        st_e           st;
        pfx_e          pfx;
        mode_t         mode;
        logic [DW-1:0] ptr;
        logic [AW-1:0] base;
        logic          done;
        okind_e        kind;
        logic          use_y;
        logic          illegal;
        logic [AW-1:0] ea;
    } regs_t;

    regs_t         q, d;
    mode_t         dec_m;
    mode_t         fin_m;
    logic [AW-1:0] fin_base;
    logic [AW-1:0] idx_sum;
    logic          fin;
    logic          take;

    oag_mode_dec i_dec (
        .opc (byte_in[7:0]),
        .pfx (q.pfx),
        .m   (dec_m)
    );

    oag_idx_add #(.AW(AW), .DW(DW)) i_add (
        .base (fin_base),
        .idx  (fin_m.use_y ? idx_y : idx_x),
        .en   (fin_m.indexed),
        .sum  (idx_sum)
    );

    assign byte_rdy    = (q.st == ST_OPC) || (q.st == ST_B1) || (q.st == ST_B2);
    assign take        = byte_vld && byte_rdy;
    assign mem_rd_en   = (q.st == ST_RA) || ((q.st == ST_RB) && q.mode.wide);
    assign mem_rd_addr = AW'(q.ptr) + ((q.st == ST_RB) ? AW'(1) : AW'(0));

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        fin      = 1'b0;
        fin_m    = q.mode;
        fin_base = q.base;
        case (q.st)
            ST_OPC: if (take) begin
                if ((q.pfx == PF_NONE) && (pfx_of(byte_in[7:0]) != PF_NONE)) begin
                    d.pfx = pfx_of(byte_in[7:0]);
                end else begin
                    d.pfx  = PF_NONE;
                    d.mode = dec_m;
                    if (dec_m.nbytes == 2'd0) begin
                        fin      = 1'b1;
                        fin_m    = dec_m;
                        fin_base = '0;
                    end else begin
                        d.st = ST_B1;
                    end
                end
            end
            ST_B1: if (take) begin
                d.base = AW'(byte_in);
                d.ptr  = byte_in;
                if (q.mode.nbytes == 2'd2) begin
                    d.st = ST_B2;
                end else if (q.mode.indirect) begin
                    d.st = ST_RA;
                end else begin
                    fin      = 1'b1;
                    fin_base = AW'(byte_in);
                end
            end
            ST_B2: if (take) begin
                fin      = 1'b1;
                fin_base = {q.base[DW-1:0], byte_in};
            end
            ST_RA: d.st = ST_RB;
            ST_RB: begin
                if (q.mode.wide) begin
                    d.base = AW'(mem_rd_data);
                    d.st   = ST_RC;
                end else begin
                    fin      = 1'b1;
                    fin_base = AW'(mem_rd_data);
                end
            end
            ST_RC: begin
                fin      = 1'b1;
                fin_base = {q.base[DW-1:0], mem_rd_data};
            end
            default: d.st = ST_OPC;
        endcase
        if (fin) begin
            d.st      = ST_OPC;
            d.done    = 1'b1;
            d.kind    = fin_m.kind;
            d.use_y   = fin_m.use_y;
            d.illegal = fin_m.illegal;
            case (fin_m.kind)
                K_MEM:   d.ea = idx_sum;
                K_IMM:   d.ea = fin_base;
                default: d.ea = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o    = q.done;
    assign ea_o      = q.ea;
    assign kind_o    = q.kind;
    assign use_y_o   = q.use_y;
    assign illegal_o = q.illegal;

    // R8: reads never leave page zero except the byte just past it
    p_rd_in_page_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_rd_addr <= AW'(2**DW)));

    // R8: back-to-back requests target consecutive addresses
    p_rd_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + AW'(1)));

    // R12: no byte is taken while a pointer read is outstanding
    p_no_take_in_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !byte_rdy);

    // R10: an illegal opcode carries no operand
    p_illegal_none_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && illegal_o) |-> (kind_o == 3'(K_NONE)));

    // R3: an immediate occupies only the low byte
    p_imm_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (kind_o == 3'(K_IMM))) |-> (ea_o[AW-1:DW] == '0));

    // R6: kinds without an index never report the second register
    p_no_y_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (kind_o != 3'(K_MEM)) && (kind_o != 3'(K_REG))) |-> !use_y_o);
endmodule

// File: tb/test_opnd_addr_gen.sv
module test_opnd_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        byte_rdy;
    logic [7:0]  idx_x = 8'h00;
    logic [7:0]  idx_y = 8'h00;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic [7:0]  mem_rd_data = 8'h00;
    logic        done_o;
    logic [15:0] ea_o;
    logic [2:0]  kind_o;
    logic        use_y_o;
    logic        illegal_o;

    int n_chk  = 0;
    int n_pass = 0;
    int n_rd   = 0;
    logic [7:0] mem [512];

    always #2 clk = ~clk;

    opnd_addr_gen i_opnd_addr_gen (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .byte_rdy(byte_rdy), .idx_x(idx_x), .idx_y(idx_y),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .done_o(done_o), .ea_o(ea_o), .kind_o(kind_o), .use_y_o(use_y_o),
        .illegal_o(illegal_o)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem[mem_rd_addr[8:0]];
            n_rd <= n_rd + 1;
        end
    end

    typedef struct packed {
        logic [7:0]  pfx;
        logic [7:0]  op;
        logic [7:0]  b1;
        logic [7:0]  b2;
        logic [7:0]  x;
        logic [7:0]  y;
        logic [2:0]  kind;
        logic [15:0] ea;
        logic        usey;
        logic        ill;
        logic [1:0]  nrd;
        logic [1:0]  nb;
        logic [2:0]  lat;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{8'h00,8'hA6,8'h5A,8'h00,8'h00,8'h00,3'd2,16'h005A,1'b0,1'b0,2'd0,2'd1,3'd1,4'd3},  // R3 imm
        '{8'h00,8'hB6,8'h77,8'h00,8'h00,8'h00,3'd1,16'h0077,1'b0,1'b0,2'd0,2'd1,3'd1,4'd3},  // R3 abs8
        '{8'h00,8'hC6,8'h12,8'h34,8'h00,8'h00,3'd1,16'h1234,1'b0,1'b0,2'd0,2'd2,3'd1,4'd3},  // R3 abs16
        '{8'h00,8'hD6,8'h12,8'hF0,8'h20,8'h00,3'd1,16'h1310,1'b0,1'b0,2'd0,2'd2,3'd1,4'd3},  // R3 idx16
        '{8'h00,8'hE6,8'hFF,8'h00,8'hFF,8'h00,3'd1,16'h01FE,1'b0,1'b0,2'd0,2'd1,3'd1,4'd5},  // R5
        '{8'h00,8'hF6,8'h00,8'h00,8'h80,8'h00,3'd1,16'h0080,1'b0,1'b0,2'd0,2'd0,3'd1,4'd3},  // R3 idx0
        '{8'h90,8'hE6,8'h10,8'h00,8'h01,8'h22,3'd1,16'h0032,1'b1,1'b0,2'd0,2'd1,3'd1,4'd6},  // R6
        '{8'h90,8'hF6,8'h00,8'h00,8'h01,8'h45,3'd1,16'h0045,1'b1,1'b0,2'd0,2'd0,3'd1,4'd6},  // R6
        '{8'h00,8'h3C,8'h99,8'h00,8'h00,8'h00,3'd1,16'h0099,1'b0,1'b0,2'd0,2'd1,3'd1,4'd4},  // R4 abs8
        '{8'h00,8'h4C,8'h00,8'h00,8'h00,8'h00,3'd3,16'h0000,1'b0,1'b0,2'd0,2'd0,3'd1,4'd4},  // R4 acc
        '{8'h00,8'h5C,8'h00,8'h00,8'h33,8'h00,3'd4,16'h0000,1'b0,1'b0,2'd0,2'd0,3'd1,4'd4},  // R4 reg
        '{8'h90,8'h5C,8'h00,8'h00,8'h00,8'h00,3'd4,16'h0000,1'b1,1'b0,2'd0,2'd0,3'd1,4'd6},  // R6 reg
        '{8'h00,8'h6C,8'h30,8'h00,8'h05,8'h00,3'd1,16'h0035,1'b0,1'b0,2'd0,2'd1,3'd1,4'd4},  // R4 idx8
        '{8'h00,8'h7C,8'h00,8'h00,8'h07,8'h00,3'd1,16'h0007,1'b0,1'b0,2'd0,2'd0,3'd1,4'd4},  // R4 idx0
        '{8'h92,8'hB6,8'h40,8'h00,8'h00,8'h00,3'd1,16'h009C,1'b0,1'b0,2'd1,2'd1,3'd3,4'd7},  // R7
        '{8'h92,8'hE6,8'h40,8'h00,8'h70,8'h00,3'd1,16'h010C,1'b0,1'b0,2'd1,2'd1,3'd3,4'd7},  // R7
        '{8'h92,8'hC6,8'h20,8'h00,8'h00,8'h00,3'd1,16'h3456,1'b0,1'b0,2'd2,2'd1,3'd4,4'd8},  // R8
        '{8'h91,8'hD6,8'h20,8'h00,8'h00,8'h10,3'd1,16'h3466,1'b1,1'b0,2'd2,2'd1,3'd4,4'd8},  // R8
        '{8'h92,8'hC6,8'hFF,8'h00,8'h00,8'h00,3'd1,16'h12AB,1'b0,1'b0,2'd2,2'd1,3'd4,4'd8},  // R8 edge
        '{8'h92,8'hA6,8'h40,8'h00,8'h00,8'h00,3'd2,16'h0040,1'b0,1'b0,2'd0,2'd1,3'd1,4'd9},  // R9
        '{8'h92,8'h4C,8'h00,8'h00,8'h00,8'h00,3'd3,16'h0000,1'b0,1'b0,2'd0,2'd0,3'd1,4'd9},  // R9
        '{8'h91,8'h5C,8'h00,8'h00,8'h00,8'h00,3'd4,16'h0000,1'b1,1'b0,2'd0,2'd0,3'd1,4'd9},  // R9
        '{8'h92,8'hF6,8'h00,8'h00,8'h11,8'h00,3'd1,16'h0011,1'b0,1'b0,2'd0,2'd0,3'd1,4'd9},  // R9
        '{8'h00,8'hA7,8'h00,8'h00,8'h00,8'h00,3'd0,16'h0000,1'b0,1'b1,2'd0,2'd0,3'd1,4'd10}, // R10
        '{8'h92,8'hA7,8'h00,8'h00,8'h00,8'h00,3'd0,16'h0000,1'b0,1'b1,2'd0,2'd0,3'd1,4'd10}, // R10
        '{8'h00,8'h81,8'h00,8'h00,8'h00,8'h00,3'd0,16'h0000,1'b0,1'b0,2'd0,2'd0,3'd1,4'd11}, // R11
        '{8'h00,8'h1C,8'h00,8'h00,8'h00,8'h00,3'd0,16'h0000,1'b0,1'b0,2'd0,2'd0,3'd1,4'd11}, // R11
        '{8'h90,8'h90,8'h00,8'h00,8'h00,8'h00,3'd0,16'h0000,1'b0,1'b0,2'd0,2'd0,3'd1,4'd2},  // R2
        '{8'h00,8'hF6,8'h00,8'h00,8'h03,8'h44,3'd1,16'h0003,1'b0,1'b0,2'd0,2'd0,3'd1,4'd2},  // R2
        '{8'h91,8'h6C,8'h41,8'h00,8'h05,8'h20,3'd1,16'h0110,1'b1,1'b0,2'd1,2'd1,3'd3,4'd7},  // R7
        '{8'h92,8'h3C,8'h40,8'h00,8'h00,8'h00,3'd1,16'h009C,1'b0,1'b0,2'd1,2'd1,3'd3,4'd7},  // R7
        '{8'h00,8'hA6,8'hFF,8'h00,8'h00,8'h00,3'd2,16'h00FF,1'b0,1'b0,2'd0,2'd1,3'd1,4'd3}   // R3
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (ok) n_pass++;
        else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    task automatic put(input logic [7:0] b);
        while (!byte_rdy) @(negedge clk);
        byte_vld = 1'b1;
        byte_in  = b;
        @(posedge clk);
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        mem[9'h020] = 8'h34; mem[9'h021] = 8'h56;
        mem[9'h040] = 8'h9C; mem[9'h041] = 8'hF0;
        mem[9'h0FF] = 8'h12; mem[9'h100] = 8'hAB;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!done_o && byte_rdy && !mem_rd_en, "R1", "reset state",
              {done_o, byte_rdy, mem_rd_en}, 3'b010);

        for (int v = 0; v < NV; v++) begin
            vec_t t;
            string rq;
            int rd0;
            int lat;
            t = VECS[v];
            rq = $sformatf("R%0d", t.req);
            idx_x = t.x;
            idx_y = t.y;
            rd0 = n_rd;
            if (t.pfx != 8'h00) put(t.pfx);
            put(t.op);
            if (t.nb >= 2'd1) put(t.b1);
            if (t.nb == 2'd2) put(t.b2);
            lat = 1;
            while (!done_o && lat < 16) begin
                @(negedge clk);
                lat++;
            end
            check(kind_o == t.kind && ea_o == t.ea && use_y_o == t.usey && illegal_o == t.ill,
                  rq, $sformatf("vector %0d kind/ea/use_y/illegal", v),
                  {kind_o, ea_o, use_y_o, illegal_o}, {t.kind, t.ea, t.usey, t.ill});
            check((n_rd - rd0) == int'(t.nrd), rq, $sformatf("vector %0d read count", v),
                  n_rd - rd0, t.nrd);
            // R12 latency from last accepted byte
            check(lat == int'(t.lat), "R12", $sformatf("vector %0d latency", v), lat, t.lat);
            @(negedge clk);
            check(!done_o, "R12", $sformatf("vector %0d done pulse width", v), done_o, 0);
        end

        // R12 / R8 directed: two-read dereference, cycle by cycle
        idx_x = 8'h00;
        put(8'h92);
        put(8'hC6);
        put(8'h20);
        check(!byte_rdy && mem_rd_en && mem_rd_addr == 16'h0020, "R8", "first read request",
              {byte_rdy, mem_rd_en, mem_rd_addr}, {2'b01, 16'h0020});
        @(negedge clk);
        check(!byte_rdy && mem_rd_en && mem_rd_addr == 16'h0021, "R8", "second read request",
              {byte_rdy, mem_rd_en, mem_rd_addr}, {2'b01, 16'h0021});
        @(negedge clk);
        check(!byte_rdy && !mem_rd_en && !done_o, "R12", "idle wait before result",
              {byte_rdy, mem_rd_en, done_o}, 3'b000);
        @(negedge clk);
        check(done_o && byte_rdy && ea_o == 16'h3456, "R12", "result on fourth cycle",
              {done_o, byte_rdy, ea_o}, {2'b11, 16'h3456});

        // R1 reset again in mid-instruction
        put(8'h92);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        put(8'h4C);
        @(negedge clk);
        check(kind_o == 3'd3 && !use_y_o, "R1", "prefix dropped by reset",
              {kind_o, use_y_o}, {3'd3, 1'b0});

        $display("%0d/%0d checks passed", n_pass, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_pass, n_chk + 1);
        $finish;
    end
endmodule